// File: doc/BRIEF.md
# Rectangle Copy and Solid Fill Engine

This block is a small 2D drawing engine that works on a frame memory of 32-bit words. Software sets up a set of operand inputs (source and destination base offsets, pitches, X/Y origins, rectangle size, pixel data-type code, mix control word, brush colour and the two palette colours). It then pulses `start`. The engine samples all operands on the accepted start, checks the whole rectangle against the memory size, and then copies a source rectangle or fills a destination rectangle through a simple synchronous memory port.

The operation is picked by an 8-bit raster-operation code in the mix control word. Four codes are acted on: a source copy, a fill with the byte-reversed brush colour, and fills with black or white built from the palette. Anything the engine cannot do is refused without touching memory. Refused cases are an unknown operation code, an unknown pixel data type, and a rectangle that would run past the end of memory. When an operation ends, the engine presents updated destination coordinates. A copy advances both X and Y. A fill advances only Y.

Top module: `rect_engine`

## Requirements
- R1: The operation code is mix_ctl[23:16]; 0xCC copies, 0xF0 fills with the brush colour, 0x00 fills black, 0xFF fills white; all other mix_ctl bits are ignored, and any other code ends with done and err set, no memory access and coordinates returned unchanged.
- R2: data_type[3:0] selects bits per pixel: 2 gives 8, 3 and 4 give 16, 5 gives 24, 6 gives 32; any other code ends with done and err set and no memory access.
- R3: The brush fill value is brush_fg with its byte order reversed (bits 7:0 land in 31:24).
- R4: The black and white fill values are {pal_black, 8'hFF} and {pal_white, 8'hFF}, with red in bits 23:16 of each palette input.
- R5: Pixel (i, j) of a rectangle sits at word base + (Y + j) * stride + X + i, where stride is the pitch divided by four with the remainder dropped, and each pixel occupies one word.
- R6: With pitch_pixels set, each pitch is multiplied by bits per pixel before the divide by four, and disp_ofs[26:0] is added to both bases; disp_ofs[31:27] is ignored.
- R7: An operation is refused (done and err, no memory access) unless, for the destination and also the source of a copy, both base and base + (Y + H) * stride + X are below MEM_WORDS.
- R8: Pixels are visited row by row from the top, left to right; a fill writes one pixel per cycle; a copy reads a pixel in one cycle and, in the next cycle, writes the returned read data.
- R9: done is a one-cycle pulse; counting from the edge that accepts start, it is high after edge 2 for a refused or empty operation, after edge N + 2 for a fill of N pixels and after edge 2N + 2 for a copy of N pixels.
- R10: With done, new_dst_x/new_dst_y show dst_x + width and dst_y + height after a copy, dst_x and dst_y + height after a fill, and dst_x and dst_y after a refusal; they hold until the next completion.
- R11: A width or height of zero ends with done, no memory access and the coordinate update of R10.
- R12: start is ignored while busy; operands that change during an operation do not affect it.
- R13: busy is high from the accepting edge until done; err clears on an accepted start and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse |
| mix_ctl | input | 32 | Mix control word, operation code in bits 23:16 |
| data_type | input | 4 | Pixel data-type code |
| pitch_pixels | input | 1 | Pitches given in pixels, add display offset |
| disp_ofs | input | 32 | Display base offset in words, low 27 bits used |
| src_ofs | input | OFS_W | Source base in words |
| dst_ofs | input | OFS_W | Destination base in words |
| src_pitch | input | PITCH_W | Source pitch |
| dst_pitch | input | PITCH_W | Destination pitch |
| src_x | input | COORD_W | Source X origin |
| src_y | input | COORD_W | Source Y origin |
| dst_x | input | COORD_W | Destination X origin |
| dst_y | input | COORD_W | Destination Y origin |
| width | input | COORD_W | Rectangle width in pixels |
| height | input | COORD_W | Rectangle height in rows |
| brush_fg | input | 32 | Brush foreground colour |
| pal_black | input | 24 | Palette colour for black fill |
| pal_white | input | 24 | Palette colour for white fill |
| mem_addr | output | ADDR_W | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last operation was refused |
| new_dst_x | output | COORD_W | Updated destination X |
| new_dst_y | output | COORD_W | Updated destination Y |

## Verification
The accepting edge takes one cycle to sample the operands. One more edge evaluates the checks, so busy is high and err clear one cycle after start. Done then follows after 2, N + 2 or 2N + 2 edges, depending on whether the operation is refused or empty, a fill, or a copy. The bench drives start on a falling edge and counts falling edges until done rises. It compares that count with the figure above, and it samples coordinates, err and the write count on that same falling edge. One cycle later it confirms that done has dropped. Only then does it compare the whole memory image with a model built from the requirements.

// File: rtl/rect_pkg.sv
package rect_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_COPY  = 3'd1,
        OP_BRUSH = 3'd2,
        OP_BLACK = 3'd3,
        OP_WHITE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } st_e;

    localparam logic [7:0] ROP_COPY  = 8'hCC;
    localparam logic [7:0] ROP_BRUSH = 8'hF0;
    localparam logic [7:0] ROP_BLACK = 8'h00;
    localparam logic [7:0] ROP_WHITE = 8'hFF;

    // Bits per pixel for a data-type code; zero marks an unknown code.
    function automatic logic [5:0] bpp_of(input logic [3:0] code);
        case (code)
            4'd2:       return 6'd8;
            4'd3, 4'd4: return 6'd16;
            4'd5:       return 6'd24;
            4'd6:       return 6'd32;
            default:    return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/rect_decode.sv
module rect_decode
    import rect_pkg::*;
(
    input  logic [7:0]  rop,
    input  logic [3:0]  dtype,
    input  logic [31:0] brush,
    input  logic [23:0] blk_rgb,
    input  logic [23:0] wht_rgb,
    output op_e         op,
    output logic [5:0]  bpp,
    output logic [31:0] fill
);

    always_comb begin
        case (rop)
            ROP_COPY:  op = OP_COPY;
            ROP_BRUSH: op = OP_BRUSH;
            ROP_BLACK: op = OP_BLACK;
            ROP_WHITE: op = OP_WHITE;
            default:   op = OP_NONE;
        endcase
    end

    assign bpp = bpp_of(dtype);

    always_comb begin
        case (op)
            OP_BRUSH: fill = {brush[7:0], brush[15:8], brush[23:16], brush[31:24]};
            OP_BLACK: fill = {blk_rgb, 8'hFF};
            OP_WHITE: fill = {wht_rgb, 8'hFF};
            default:  fill = 32'd0;
        endcase
    end

endmodule

// File: rtl/rect_bounds.sv
module rect_bounds #(
    parameter int MEM_WORDS = 4096,
    parameter int OFS_W     = 20,
    parameter int COORD_W   = 12,
    parameter int PITCH_W   = 14,
    parameter int DISP_W    = 27,
    parameter int ADDR_W    = $clog2(MEM_WORDS),
    parameter int EXT_W     = 64
) (
    input  logic [OFS_W-1:0]   base,
    input  logic [DISP_W-1:0]  disp,
    input  logic               pix_mode,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [5:0]         bpp,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] rows,
    output logic [ADDR_W-1:0]  first,
    output logic [ADDR_W-1:0]  stride,
    output logic               in_range
);

    logic [EXT_W-1:0] pitch_eff, stride_x, base_eff, first_x, limit_x, mem_x;

    always_comb begin
        mem_x     = EXT_W'(MEM_WORDS);
        pitch_eff = pix_mode ? EXT_W'(pitch) * EXT_W'(bpp) : EXT_W'(pitch);
        stride_x  = pitch_eff >> 2;
        base_eff  = EXT_W'(base) + (pix_mode ? EXT_W'(disp) : '0);
        first_x   = base_eff + EXT_W'(org_y) * stride_x + EXT_W'(org_x);
        limit_x   = base_eff + (EXT_W'(org_y) + EXT_W'(rows)) * stride_x + EXT_W'(org_x);
        in_range  = (base_eff < mem_x) && (limit_x < mem_x);
        first     = first_x[ADDR_W-1:0];
        stride    = stride_x[ADDR_W-1:0];
    end

endmodule

// File: rtl/rect_engine.sv
module rect_engine
    import rect_pkg::*;
#(
    parameter int MEM_WORDS = 4096,
    parameter int OFS_W     = 20,
    parameter int COORD_W   = 12,
    parameter int PITCH_W   = 14,
    parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        mix_ctl,
    input  logic [3:0]         data_type,
    input  logic               pitch_pixels,
    input  logic [31:0]        disp_ofs,
    input  logic [OFS_W-1:0]   src_ofs,
    input  logic [OFS_W-1:0]   dst_ofs,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    input  logic [31:0]        brush_fg,
    input  logic [23:0]        pal_black,
    input  logic [23:0]        pal_white,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [COORD_W-1:0] new_dst_x,
    output logic [COORD_W-1:0] new_dst_y
);

    localparam int DISP_W = 27;
    localparam int BIG_W  = (OFS_W > DISP_W) ? OFS_W : DISP_W;
    localparam int EXT_W  = BIG_W + COORD_W + PITCH_W + 9;

    typedef struct packed {
        logic [7:0]         rop;
        logic [3:0]         dtype;
        logic               pix;
        logic [DISP_W-1:0]  disp;
        logic [OFS_W-1:0]   sofs;
        logic [OFS_W-1:0]   dofs;
        logic [PITCH_W-1:0] sp;
        logic [PITCH_W-1:0] dp;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] h;
        logic [31:0]        brush;
        logic [23:0]        blk;
        logic [23:0]        wht;
    } cfg_t;

    typedef struct packed {
        st_e                st;
        logic               done;
        logic               err;
        cfg_t               cfg;
        logic [ADDR_W-1:0]  srow;
        logic [ADDR_W-1:0]  drow;
        logic [COORD_W-1:0] col;
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] ox;
        logic [COORD_W-1:0] oy;
    } state_t;

    state_t s_q, s_d;

    // Bits of the operand words that play no part in the engine.
    logic unused_bits;
    assign unused_bits = ^{mix_ctl[31:24], mix_ctl[15:0], disp_ofs[31:27]};

    // ---------------- decode of the latched operands ----------------
    op_e         op;
    logic [5:0]  bpp;
    logic [31:0] fill;

    rect_decode u_dec (
        .rop     (s_q.cfg.rop),
        .dtype   (s_q.cfg.dtype),
        .brush   (s_q.cfg.brush),
        .blk_rgb (s_q.cfg.blk),
        .wht_rgb (s_q.cfg.wht),
        .op      (op),
        .bpp     (bpp),
        .fill    (fill)
    );

    // ---------------- address bases and range checks ----------------
    logic [ADDR_W-1:0] src_first, dst_first, src_stride, dst_stride;
    logic              src_ok, dst_ok;

    rect_bounds #(
        .MEM_WORDS (MEM_WORDS), .OFS_W (OFS_W), .COORD_W (COORD_W),
        .PITCH_W (PITCH_W), .DISP_W (DISP_W), .ADDR_W (ADDR_W), .EXT_W (EXT_W)
    ) u_src_bnd (
        .base     (s_q.cfg.sofs),
        .disp     (s_q.cfg.disp),
        .pix_mode (s_q.cfg.pix),
        .pitch    (s_q.cfg.sp),
        .bpp      (bpp),
        .org_x    (s_q.cfg.sx),
        .org_y    (s_q.cfg.sy),
        .rows     (s_q.cfg.h),
        .first    (src_first),
        .stride   (src_stride),
        .in_range (src_ok)
    );

    rect_bounds #(
        .MEM_WORDS (MEM_WORDS), .OFS_W (OFS_W), .COORD_W (COORD_W),
        .PITCH_W (PITCH_W), .DISP_W (DISP_W), .ADDR_W (ADDR_W), .EXT_W (EXT_W)
    ) u_dst_bnd (
        .base     (s_q.cfg.dofs),
        .disp     (s_q.cfg.disp),
        .pix_mode (s_q.cfg.pix),
        .pitch    (s_q.cfg.dp),
        .bpp      (bpp),
        .org_x    (s_q.cfg.dx),
        .org_y    (s_q.cfg.dy),
        .rows     (s_q.cfg.h),
        .first    (dst_first),
        .stride   (dst_stride),
        .in_range (dst_ok)
    );

    // ---------------- next-state logic ----------------
    logic is_copy, refuse, empty, last_col, last_row;

    always_comb begin
        is_copy  = (op == OP_COPY);
        refuse   = (op == OP_NONE) || (bpp == 6'd0) || !dst_ok || (is_copy && !src_ok);
        empty    = (s_q.cfg.w == '0) || (s_q.cfg.h == '0);
        last_col = (s_q.col == s_q.cfg.w - 1'b1);
        last_row = (s_q.row == s_q.cfg.h - 1'b1);

        s_d      = s_q;
        s_d.done = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st        = ST_CALC;
                    s_d.err       = 1'b0;
                    s_d.cfg.rop   = mix_ctl[23:16];
                    s_d.cfg.dtype = data_type;
                    s_d.cfg.pix   = pitch_pixels;
                    s_d.cfg.disp  = disp_ofs[DISP_W-1:0];
                    s_d.cfg.sofs  = src_ofs;
                    s_d.cfg.dofs  = dst_ofs;
                    s_d.cfg.sp    = src_pitch;
                    s_d.cfg.dp    = dst_pitch;
                    s_d.cfg.sx    = src_x;
                    s_d.cfg.sy    = src_y;
                    s_d.cfg.dx    = dst_x;
                    s_d.cfg.dy    = dst_y;
                    s_d.cfg.w     = width;
                    s_d.cfg.h     = height;
                    s_d.cfg.brush = brush_fg;
                    s_d.cfg.blk   = pal_black;
                    s_d.cfg.wht   = pal_white;
                end
            end
            ST_CALC: begin
                if (refuse) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                    s_d.ox   = s_q.cfg.dx;
                    s_d.oy   = s_q.cfg.dy;
                end else if (empty) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.ox   = is_copy ? s_q.cfg.dx + s_q.cfg.w : s_q.cfg.dx;
                    s_d.oy   = s_q.cfg.dy + s_q.cfg.h;
                end else begin
                    s_d.st   = is_copy ? ST_READ : ST_WRITE;
                    s_d.srow = src_first;
                    s_d.drow = dst_first;
                    s_d.col  = '0;
                    s_d.row  = '0;
                end
            end
            ST_READ: begin
                s_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (last_col && last_row) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.ox   = is_copy ? s_q.cfg.dx + s_q.cfg.w : s_q.cfg.dx;
                    s_d.oy   = s_q.cfg.dy + s_q.cfg.h;
                end else begin
                    s_d.st = is_copy ? ST_READ : ST_WRITE;
                    if (last_col) begin
                        s_d.col  = '0;
                        s_d.row  = s_q.row + 1'b1;
                        s_d.srow = s_q.srow + src_stride;
                        s_d.drow = s_q.drow + dst_stride;
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- outputs ----------------
    logic [ADDR_W-1:0] col_a;
    assign col_a     = ADDR_W'(s_q.col);
    assign mem_re    = (s_q.st == ST_READ);
    assign mem_we    = (s_q.st == ST_WRITE);
    assign mem_addr  = mem_re ? s_q.srow + col_a : s_q.drow + col_a;
    assign mem_wdata = is_copy ? mem_rdata : fill;
    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign new_dst_x = s_q.ox;
    assign new_dst_y = s_q.oy;

    // ---------------- assertions ----------------
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_copy_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && is_copy) |-> $past(mem_re));

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re));

    a_r12_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.cfg));

    a_r4_palette_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (op == OP_BLACK || op == OP_WHITE)) |-> (mem_wdata[7:0] == 8'hFF));

    a_r13_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |=> $stable(err));

endmodule

// File: tb/rect_engine_test.sv
module rect_engine_test;

    localparam int MW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mix_ctl = '0;
    logic [3:0]  data_type = '0;
    logic        pitch_pixels = 1'b0;
    logic [31:0] disp_ofs = '0;
    logic [19:0] src_ofs = '0, dst_ofs = '0;
    logic [13:0] src_pitch = '0, dst_pitch = '0;
    logic [11:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, width = '0, height = '0;
    logic [31:0] brush_fg = '0;
    logic [23:0] pal_black = '0, pal_white = '0;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we, busy, done, err;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [11:0] new_dst_x, new_dst_y;

    logic [31:0] mem     [0:MW-1];
    logic [31:0] exp_mem [0:MW-1];
    int wr_cnt = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rect_engine uut (
        .clk (clk), .rst_n (rst_n), .start (start), .mix_ctl (mix_ctl),
        .data_type (data_type), .pitch_pixels (pitch_pixels), .disp_ofs (disp_ofs),
        .src_ofs (src_ofs), .dst_ofs (dst_ofs), .src_pitch (src_pitch),
        .dst_pitch (dst_pitch), .src_x (src_x), .src_y (src_y), .dst_x (dst_x),
        .dst_y (dst_y), .width (width), .height (height), .brush_fg (brush_fg),
        .pal_black (pal_black), .pal_white (pal_white), .mem_addr (mem_addr),
        .mem_re (mem_re), .mem_we (mem_we), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .busy (busy), .done (done), .err (err),
        .new_dst_x (new_dst_x), .new_dst_y (new_dst_y)
    );

    // Memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < MW; i++) begin
            mem[i]     = 32'hA500_0000 | i;
            exp_mem[i] = 32'hA500_0000 | i;
        end
    endtask

    task automatic model_fill(input int base, input int stride, input int x, input int y,
                              input int w, input int h, input logic [31:0] v);
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                exp_mem[base + (y + j) * stride + x + i] = v;
    endtask

    task automatic model_copy(input int sb, input int ss, input int sx, input int sy,
                              input int db, input int ds, input int dx, input int dy,
                              input int w, input int h);
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                exp_mem[db + (dy + j) * ds + dx + i] = exp_mem[sb + (sy + j) * ss + sx + i];
    endtask

    task automatic mem_compare(input string req);
        int miss = 0;
        int first = -1;
        for (int i = 0; i < MW; i++)
            if (mem[i] !== exp_mem[i]) begin
                if (first < 0) first = i;
                miss++;
            end
        if (first < 0) chk(1'b1, req, "memory image", 0, 0);
        else chk(1'b0, req, $sformatf("memory word %0d", first), mem[first], exp_mem[first]);
    endtask

    // Launch one operation and check timing, flags, coordinates and writes.
    task automatic run_op(input string req, input int exp_lat, input bit exp_err,
                          input int exp_x, input int exp_y, input int exp_wr, input int poke);
        int n;
        int w0;
        w0 = wr_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; n = 1;
        chk(busy == 1'b1 && err == 1'b0, "R13", "busy/err after start", {busy, err}, 2'b10);
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
            if (n == poke) begin
                start = 1'b1;
                dst_ofs = 20'd3000;
                mix_ctl = 32'h00CC_0000;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(n == exp_lat, "R9", {req, " done latency"}, n, exp_lat);
        chk(err == exp_err, req, "err", err, exp_err);
        chk(new_dst_x == exp_x[11:0] && new_dst_y == exp_y[11:0], "R10",
            {req, " coordinates"}, {new_dst_x, new_dst_y}, {exp_x[11:0], exp_y[11:0]});
        chk(wr_cnt - w0 == exp_wr, "R8", {req, " write count"}, wr_cnt - w0, exp_wr);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done pulse width", {done, busy}, 0);
        mem_compare(req);
    endtask

    task automatic set_fill(input logic [7:0] rop, input logic [3:0] dt, input int base,
                            input int pitch, input int x, input int y, input int w, input int h);
        mix_ctl = {8'h5A, rop, 16'h3C71};
        data_type = dt;
        pitch_pixels = 1'b0;
        dst_ofs = base[19:0];
        dst_pitch = pitch[13:0];
        dst_x = x[11:0]; dst_y = y[11:0];
        width = w[11:0]; height = h[11:0];
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && err == 0 && mem_we == 0 && mem_re == 0,
            "R13", "reset state", {busy, done, err, mem_we, mem_re}, 0);
        chk(new_dst_x == 0 && new_dst_y == 0, "R10", "reset coordinates",
            {new_dst_x, new_dst_y}, 0);
    endtask

    task automatic t_brush_fill();
        // R3 R1 R5: 8 bpp, stride 16/4 = 4, 6 pixels.
        set_fill(8'hF0, 4'd2, 100, 16, 1, 2, 3, 2);
        brush_fg = 32'h1122_3344;
        model_fill(100, 4, 1, 2, 3, 2, 32'h4433_2211);
        run_op("R3", 8, 1'b0, 1, 4, 6, 0);
    endtask

    task automatic t_black_fill();
        // R4 R2: 32 bpp, pitch 42 -> stride 10 (remainder dropped).
        set_fill(8'h00, 4'd6, 200, 42, 0, 0, 2, 3);
        pal_black = 24'h10_20_30;
        model_fill(200, 10, 0, 0, 2, 3, 32'h1020_30FF);
        run_op("R4", 8, 1'b0, 0, 3, 6, 0);
    endtask

    task automatic t_white_fill();
        // R4 R2: 16 bpp code 3, stride 3.
        set_fill(8'hFF, 4'd3, 400, 12, 2, 1, 1, 4);
        pal_white = 24'hA0_B0_C0;
        model_fill(400, 3, 2, 1, 1, 4, 32'hA0B0_C0FF);
        run_op("R4", 6, 1'b0, 2, 5, 4, 0);
    endtask

    task automatic t_copy();
        // R1 R5 R8: 16 bpp code 4, 12 pixels.
        set_fill(8'hCC, 4'd4, 600, 20, 1, 0, 4, 3);
        src_ofs = 20'd300; src_pitch = 14'd32; src_x = 12'd2; src_y = 12'd1;
        model_copy(300, 8, 2, 1, 600, 5, 1, 0, 4, 3);
        run_op("R8", 26, 1'b0, 5, 3, 12, 0);
    endtask

    task automatic t_pixel_pitch();
        // R6: 24 bpp, src pitch 4 px -> 24, dst 2 px -> 12, display offset 0x400.
        set_fill(8'hCC, 4'd5, 500, 2, 1, 1, 2, 2);
        pitch_pixels = 1'b1;
        disp_ofs = 32'hF800_0400;
        src_ofs = 20'd10; src_pitch = 14'd4; src_x = 12'd0; src_y = 12'd0;
        model_copy(1034, 24, 0, 0, 1524, 12, 1, 1, 2, 2);
        run_op("R6", 10, 1'b0, 3, 3, 4, 0);
        pitch_pixels = 1'b0;
        disp_ofs = '0;
    endtask

    task automatic t_bad_type();
        // R2: code 9 refused; R13 err holds afterwards.
        set_fill(8'hF0, 4'd9, 100, 16, 7, 8, 3, 2);
        run_op("R2", 2, 1'b1, 7, 8, 0, 0);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R13", "err held while idle", err, 1);
    endtask

    task automatic t_bad_rop();
        // R1: code 0x66 not acted on.
        set_fill(8'h66, 4'd6, 100, 16, 5, 6, 3, 2);
        run_op("R1", 2, 1'b1, 5, 6, 0, 0);
    endtask

    task automatic t_out_of_range();
        // R7: 4000 + (10+2)*16 = 4192 is past the end.
        set_fill(8'hFF, 4'd6, 4000, 64, 0, 10, 1, 2);
        run_op("R7", 2, 1'b1, 0, 10, 0, 0);
        // R7: base itself past the end.
        set_fill(8'h00, 4'd6, 5000, 4, 0, 0, 1, 1);
        run_op("R7", 2, 1'b1, 0, 0, 0, 0);
        // R7: destination fine, copy source 4090 + (0+1)*4 + 3 = 4097 too far.
        set_fill(8'hCC, 4'd6, 100, 16, 0, 0, 1, 1);
        src_ofs = 20'd4090; src_pitch = 14'd16; src_x = 12'd3; src_y = 12'd0;
        run_op("R7", 2, 1'b1, 0, 0, 0, 0);
    endtask

    task automatic t_empty();
        // R11: zero width copy and zero height fill.
        set_fill(8'hCC, 4'd6, 100, 16, 3, 4, 0, 5);
        src_ofs = 20'd0; src_pitch = 14'd16; src_x = 12'd0; src_y = 12'd0;
        run_op("R11", 2, 1'b0, 3, 9, 0, 0);
        set_fill(8'hF0, 4'd6, 100, 16, 3, 4, 2, 0);
        run_op("R11", 2, 1'b0, 3, 4, 0, 0);
    endtask

    task automatic t_start_busy();
        // R12: start and operands changed mid-operation have no effect.
        set_fill(8'hF0, 4'd2, 700, 16, 0, 0, 3, 2);
        brush_fg = 32'hDEAD_BEEF;
        model_fill(700, 4, 0, 0, 3, 2, 32'hEFBE_ADDE);
        run_op("R12", 8, 1'b0, 0, 2, 6, 3);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12", "no second operation", busy, 0);
    endtask

    initial begin
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_brush_fill();
        t_black_fill();
        t_white_fill();
        t_copy();
        t_pixel_pitch();
        t_bad_type();
        t_bad_rop();
        t_out_of_range();
        t_empty();
        t_start_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule